// File: doc/BRIEF.md
# Fair Tree-Bus Ownership Arbiter

This block is the central arbiter for a serial bus whose nodes form a tree. It hands bus ownership to at most one of `N_NODES` nodes at a time. Each node has a request line. Each node also has static configuration: its hop distance from the root, a node number, and an urgent attribute. The arbiter keeps a record of when each request arrived and serves the oldest one first. Requests that arrive in the same clock are ordered by shallower depth, and then by smaller node number.

Fairness works in intervals. An interval begins with a one-cycle pulse, and at that point every node receives a fresh permission to arbitrate. A normal node spends its permission when it wins, and it stays locked out until the next pulse. Urgent nodes may win without a permission. Their share of the bus is still bounded: once three urgent grants have been made since the last normal grant, a waiting normal node with permission goes ahead of any urgent request.

A grant lasts until the owner pulses `bus_release`. A granted request is consumed by the grant, so a node that wants the bus again must lower its request and raise it once more.

Top module: `fair_bus_arbiter`

## Requirements
- R1: Among eligible pending requests, the one whose request line rose earliest wins, whatever the depth and number of the nodes involved.
- R2: Requests that rose in the same cycle are ordered by smaller `node_depth`, and then by smaller `node_id`. Node i's fields sit in bits [i*DEPTH_W +: DEPTH_W] and [i*ID_W +: ID_W].
- R3: A one-cycle `interval_start` restores permission to every node. A node that is waiting on its permission is granted on the second rising edge after the pulse was sampled.
- R4: A grant to a non-urgent node removes that node's permission. A later request from the same node is not granted until the next `interval_start`.
- R5: A node with `node_urgent` high can be granted even though its permission has already been used.
- R6: Once three urgent grants have been made since the last non-urgent grant, any eligible non-urgent request beats every urgent request, including older ones. A non-urgent grant restarts that count at zero.
- R7: `grant` is one-hot or zero. A request that rises on an idle bus appears on `grant` at the second rising edge after it is sampled. `grant_valid` is high for exactly the first cycle of each new grant.
- R8: `grant` holds its value while `bus_release` is low. A sampled `bus_release` clears `grant` at that edge, and the next grant can be issued no earlier than the following edge.
- R9: A request that is lowered before it is granted leaves the pending set and keeps its permission. Re-raising it later gets a grant without an `interval_start`.
- R10: A synchronous active-high `rst` clears `grant`, `grant_valid`, the arrival records and the urgent count, and restores every permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_NODES | Per-node bus request lines |
| node_depth | input | N_NODES*DEPTH_W | Per-node hop count from the root, packed by node |
| node_id | input | N_NODES*ID_W | Per-node number, packed by node |
| node_urgent | input | N_NODES | Per-node urgent attribute |
| interval_start | input | 1 | One-cycle pulse that opens a new fairness interval |
| bus_release | input | 1 | Owner gives up the bus |
| grant | output | N_NODES | Registered one-hot ownership vector |
| grant_valid | output | 1 | High in the first cycle of a new grant |

## Verification
The assertions rely on three things about the inputs. The configuration inputs do not change while requests are outstanding. Node numbers are distinct. No request waits longer than 2^TS_W cycles, which keeps the age arithmetic free of wrap-around. The stimulus follows all three: configuration is loaded only while the design is held in reset, the chosen numbers are unique, and every scenario finishes within a few dozen cycles. `bus_release` is driven only while some node owns the bus, and the bench lowers the owner's request in the same cycle so that nothing is re-requested by accident.

// File: rtl/fba_pkg.sv
package fba_pkg;
  typedef enum logic {
    OWN_IDLE = 1'b0,
    OWN_HELD = 1'b1
  } own_e;
endpackage

// File: rtl/fba_arrival.sv
// Per-node arrival tracking: pending flag plus the time the request rose.
module fba_arrival #(
  parameter int N    = 4,
  parameter int TS_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      req,
  input  logic              fire,
  input  logic [N-1:0]      win_oh,
  output logic [N-1:0]      pend,
  output logic [N*TS_W-1:0] stamp,
  output logic [TS_W-1:0]   now
);
  logic [N-1:0] req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      now   <= '0;
      req_q <= '0;
    end else begin
      now   <= now + 1'b1;
      req_q <= req;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_node
    always_ff @(posedge clk) begin
      if (rst) begin
        pend[g]                <= 1'b0;
        stamp[g*TS_W +: TS_W]  <= '0;
      end else if (!req[g]) begin
        pend[g] <= 1'b0;
      end else if (!req_q[g]) begin
        pend[g]               <= 1'b1;
        stamp[g*TS_W +: TS_W] <= now;
      end else if (fire && win_oh[g]) begin
        pend[g] <= 1'b0;
      end
    end

    // R9: a lowered request leaves the pending set
    a_r9_drop_clears: assert property (@(posedge clk) disable iff (rst)
      !req[g] |=> !pend[g]);
  end
endmodule

// File: rtl/fba_fairness.sv
// Permission flags per node and the urgent-share counter.
module fba_fairness #(
  parameter int N     = 4,
  parameter int RATIO = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         interval_start,
  input  logic [N-1:0] cand,
  input  logic [N-1:0] urgent,
  input  logic         fire,
  input  logic [N-1:0] win_oh,
  input  logic         win_urgent,
  output logic [N-1:0] elig
);
  localparam int CNT_W = $clog2(RATIO + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RATIO);

  logic [N-1:0]     en;
  logic [N-1:0]     norm_ok;
  logic [CNT_W-1:0] ucnt;
  logic             hold_urg;

  always_comb begin
    norm_ok  = cand & ~urgent & en;
    hold_urg = (ucnt == CNT_MAX) && (|norm_ok);
    elig     = norm_ok | (cand & urgent & {N{~hold_urg}});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= '1;
      ucnt <= '0;
    end else begin
      if (interval_start)
        en <= '1;
      else if (fire)
        en <= en & ~win_oh;
      if (fire) begin
        if (!win_urgent)
          ucnt <= '0;
        else if (ucnt != CNT_MAX)
          ucnt <= ucnt + 1'b1;
      end
    end
  end

  // R3: every permission restored after an interval pulse
  a_r3_interval_sets: assert property (@(posedge clk) disable iff (rst)
    interval_start |=> (&en));

  // R4: a normal winner loses its permission
  a_r4_flag_spent: assert property (@(posedge clk) disable iff (rst)
    (fire && !win_urgent && !interval_start) |=> ((en & $past(win_oh)) == '0));

  // R6: a normal grant restarts the urgent count
  a_r6_count_restart: assert property (@(posedge clk) disable iff (rst)
    (fire && !win_urgent) |=> (ucnt == '0));
endmodule

// File: rtl/fba_select.sv
// Oldest-first selection with depth and number as tie-breaks.
module fba_select #(
  parameter int N       = 4,
  parameter int DEPTH_W = 3,
  parameter int ID_W    = 4,
  parameter int TS_W    = 8
) (
  input  logic [N-1:0]         elig,
  input  logic [TS_W-1:0]      now,
  input  logic [N*TS_W-1:0]    stamp,
  input  logic [N*DEPTH_W-1:0] depth,
  input  logic [N*ID_W-1:0]    ids,
  output logic [N-1:0]         win_oh,
  output logic                 any
);
  logic [TS_W-1:0]    best_age, cur_age;
  logic [DEPTH_W-1:0] best_dep, cur_dep;
  logic [ID_W-1:0]    best_id, cur_id;
  logic               better;

  always_comb begin
    win_oh   = '0;
    any      = 1'b0;
    best_age = '0;
    best_dep = '0;
    best_id  = '0;
    cur_age  = '0;
    cur_dep  = '0;
    cur_id   = '0;
    better   = 1'b0;
    for (int i = 0; i < N; i++) begin
      cur_age = now - stamp[i*TS_W +: TS_W];
      cur_dep = depth[i*DEPTH_W +: DEPTH_W];
      cur_id  = ids[i*ID_W +: ID_W];
      better  = (cur_age > best_age) ||
                ((cur_age == best_age) && (cur_dep < best_dep)) ||
                ((cur_age == best_age) && (cur_dep == best_dep) && (cur_id < best_id));
      if (elig[i] && (!any || better)) begin
        any      = 1'b1;
        win_oh   = N'(1) << i;
        best_age = cur_age;
        best_dep = cur_dep;
        best_id  = cur_id;
      end
    end
  end
endmodule

// File: rtl/fair_bus_arbiter.sv
module fair_bus_arbiter #(
  parameter int N_NODES      = 4,
  parameter int DEPTH_W      = 3,
  parameter int ID_W         = 4,
  parameter int TS_W         = 8,
  parameter int URGENT_RATIO = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_NODES-1:0]         req,
  input  logic [N_NODES*DEPTH_W-1:0] node_depth,
  input  logic [N_NODES*ID_W-1:0]    node_id,
  input  logic [N_NODES-1:0]         node_urgent,
  input  logic                       interval_start,
  input  logic                       bus_release,
  output logic [N_NODES-1:0]         grant,
  output logic                       grant_valid
);
  import fba_pkg::*;

  own_e                      own_q;
  logic [N_NODES-1:0]        pend, elig, win_oh;
  logic [N_NODES*TS_W-1:0]   stamp;
  logic [TS_W-1:0]           now;
  logic                      any, fire, win_urgent;

  assign fire       = (own_q == OWN_IDLE) && any;
  assign win_urgent = |(win_oh & node_urgent);

  fba_arrival #(.N(N_NODES), .TS_W(TS_W)) u_arrival (
    .clk(clk), .rst(rst), .req(req), .fire(fire), .win_oh(win_oh),
    .pend(pend), .stamp(stamp), .now(now)
  );

  fba_fairness #(.N(N_NODES), .RATIO(URGENT_RATIO)) u_fair (
    .clk(clk), .rst(rst), .interval_start(interval_start),
    .cand(pend & req), .urgent(node_urgent), .fire(fire),
    .win_oh(win_oh), .win_urgent(win_urgent), .elig(elig)
  );

  fba_select #(.N(N_NODES), .DEPTH_W(DEPTH_W), .ID_W(ID_W), .TS_W(TS_W)) u_sel (
    .elig(elig), .now(now), .stamp(stamp), .depth(node_depth),
    .ids(node_id), .win_oh(win_oh), .any(any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q       <= OWN_IDLE;
      grant       <= '0;
      grant_valid <= 1'b0;
    end else begin
      grant_valid <= fire;
      if (own_q == OWN_HELD && bus_release) begin
        own_q <= OWN_IDLE;
        grant <= '0;
      end else if (fire) begin
        own_q <= OWN_HELD;
        grant <= win_oh;
      end
    end
  end

  // R7: never more than one owner
  a_r7_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R7: the strobe accompanies exactly one owner
  a_r7_valid_owner: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> ($countones(grant) == 1));

  // R8: ownership is stable until released
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    ((|grant) && !bus_release) |=> $stable(grant));

  // R8: release empties the bus
  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    ((|grant) && bus_release) |=> (grant == '0));
endmodule

// File: tb/fair_bus_arbiter_bench.sv
`timescale 1ns/1ps
module fair_bus_arbiter_bench;
  localparam int N = 4;
  localparam int DW = 3;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    req = '0;
  logic [N*DW-1:0] depth_flat = '0;
  logic [N*IW-1:0] id_flat = '0;
  logic [N-1:0]    urgent = '0;
  logic interval_start = 1'b0;
  logic bus_release = 1'b0;
  logic [N-1:0] grant;
  logic grant_valid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int dep [N];
  int idn [N];

  always #2.5 clk = ~clk;

  fair_bus_arbiter u_fair_bus_arbiter (
    .clk(clk), .rst(rst), .req(req), .node_depth(depth_flat),
    .node_id(id_flat), .node_urgent(urgent),
    .interval_start(interval_start), .bus_release(bus_release),
    .grant(grant), .grant_valid(grant_valid)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply_cfg();
    for (int i = 0; i < N; i++) begin
      depth_flat[i*DW +: DW] = DW'(dep[i]);
      id_flat[i*IW +: IW]    = IW'(idn[i]);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; req = '0; bus_release = 1'b0; interval_start = 1'b0;
    apply_cfg();
    tick(); tick();
    rst = 1'b0;
  endtask

  // release the current owner and lower its request in the same cycle
  task automatic release_owner(input logic [N-1:0] owner);
    req = req & ~owner;
    bus_release = 1'b1;
    tick();
    bus_release = 1'b0;
  endtask

  function automatic int pick(input logic [N-1:0] m);
    int b = -1;
    for (int i = 0; i < N; i++)
      if (m[i] && (b < 0 || dep[i] < dep[b] || (dep[i] == dep[b] && idn[i] < idn[b])))
        b = i;
    return b;
  endfunction

  task automatic sweep();
    for (int m = 1; m < (1 << N); m++) begin
      logic [N-1:0] rem;
      int b;
      do_reset();
      req = N'(m);
      rem = N'(m);
      tick(); tick();
      while (rem != '0) begin
        b = pick(rem);
        chk("R2 same-cycle order", 32'(grant), 32'(N'(1) << b));
        chk("R7 strobe on new grant", 32'(grant_valid), 32'd1);
        release_owner(N'(1) << b);
        chk("R8 release clears grant", 32'(grant), 32'd0);
        rem = rem & ~(N'(1) << b);
        if (rem != '0) tick();
      end
    end
  endtask

  initial begin
    int expect_w;
    // reset state (R10)
    dep = '{2, 0, 1, 0};
    idn = '{5, 9, 3, 2};
    urgent = '0;
    do_reset();
    chk("R10 reset grant", 32'(grant), 32'd0);
    chk("R10 reset strobe", 32'(grant_valid), 32'd0);

    // simultaneous arrival sweeps over two configurations (R2, R7, R8)
    sweep();
    dep = '{1, 1, 1, 1};
    idn = '{0, 3, 1, 2};
    sweep();

    // arrival order beats static priority (R1)
    dep = '{2, 0, 1, 0};
    idn = '{5, 9, 3, 2};
    do_reset();
    req = 4'b0001;
    tick(); tick();
    chk("R7 grant latency", 32'(grant), 32'h1);
    req = req | 4'b0100;
    tick();
    chk("R7 strobe one cycle", 32'(grant_valid), 32'd0);
    chk("R8 grant held", 32'(grant), 32'h1);
    req = req | 4'b1000;
    tick(); tick();
    chk("R8 grant held with others waiting", 32'(grant), 32'h1);
    release_owner(4'b0001);
    tick();
    chk("R1 older request first", 32'(grant), 32'h4);
    release_owner(4'b0100);
    tick();
    chk("R1 younger request next", 32'(grant), 32'h8);

    // permission spent until next interval (R4, R3, R10)
    do_reset();
    req = 4'b0010;
    tick(); tick();
    chk("R10 permission present after reset", 32'(grant), 32'h2);
    release_owner(4'b0010);
    req = 4'b0010;
    tick(); tick(); tick(); tick();
    chk("R4 no second win in interval", 32'(grant), 32'd0);
    chk("R4 no strobe", 32'(grant_valid), 32'd0);
    interval_start = 1'b1;
    tick();
    interval_start = 1'b0;
    chk("R3 not before second edge", 32'(grant), 32'd0);
    tick();
    chk("R3 permission restored", 32'(grant), 32'h2);

    // dropped request leaves no trace (R9)
    do_reset();
    req = 4'b0001;
    tick(); tick();
    req = req | 4'b0100;
    tick();
    req = req & ~4'b0100;
    tick();
    release_owner(4'b0001);
    tick(); tick();
    chk("R9 withdrawn request not granted", 32'(grant), 32'd0);
    req = 4'b0100;
    tick(); tick();
    chk("R9 permission kept", 32'(grant), 32'h4);

    // urgent override and share limit (R5, R6)
    urgent = 4'b0011;
    do_reset();
    req = 4'b0001;
    tick(); tick();
    chk("R5 urgent first grant", 32'(grant), 32'h1);
    req = req | 4'b0010;
    tick();
    release_owner(4'b0001);
    tick();
    chk("R5 second urgent", 32'(grant), 32'h2);
    req = req | 4'b0001;
    tick();
    release_owner(4'b0010);
    tick();
    chk("R5 urgent wins with spent permission", 32'(grant), 32'h1);
    req = req | 4'b0010;
    tick();
    req = req | 4'b0100;
    tick();
    release_owner(4'b0001);
    tick();
    expect_w = 4;
    chk("R6 normal node after three urgent grants", 32'(grant), 32'(expect_w));
    release_owner(4'b0100);
    tick();
    chk("R6 count restarted, urgent served", 32'(grant), 32'h2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule